// File: doc/BRIEF.md
# Warm and Cold Reset Sequencer

This block produces the system reset for a small microcontroller core. It handles three sources. The first is an asynchronous power-on input, which is a cold reset. The second is a software request bit in a mode control register. The third is an underflow event from an external watchdog counter, which causes a reset only when an enable bit in a clock control register is set. When that bit is clear, the underflow produces a one-cycle interrupt pulse instead.

A cold reset clears every register bit. A warm reset (software or watchdog) clears all register bits except the two-bit processor-mode field, which only a register write can change. After any trigger, the reset output stays low for a fixed number of cycles and is then released on a clock edge. In the first cycle after release, the block presents the 24-bit reset-vector location to the core. A cause output records which source produced the most recent reset.

Top module: `warm_rst_ctrl`

## Requirements
- R1: While `porN` is low (asynchronously), `sysRstN` is 0, `modeReg` and `clkCtlReg` are all zeros, and `rstCause` is 2'b01 (power-on).
- R2: `sysRstN` stays 0 for exactly HOLD_CYCLES (16) clock edges, counted from the edge that accepts a warm trigger or from the first edge after `porN` rises, and then goes to 1 on a clock edge.
- R3: A write with `wrSel`=0 and `wrData` bit 3 = 1, made while `mainClkSel` and `oscStable` are both 1, sets `modeReg` bit 3. The following edge starts a reset and sets `rstCause` to 2'b10 (software).
- R4: If `mainClkSel` or `oscStable` is 0, a software request write is ignored. `modeReg` bit 3 reads 0, no reset occurs, and the other written bits are stored normally.
- R5: A `wdUnderflow` pulse sampled while `clkCtlReg` bit 0 = 1 starts a reset at that edge and sets `rstCause` to 2'b11 (watchdog).
- R6: A `wdUnderflow` pulse sampled while `clkCtlReg` bit 0 = 0 causes no reset. Instead, `wdIrq` is 1 for exactly the following cycle.
- R7: A warm reset keeps `modeReg[1:0]` (processor mode) unchanged and clears every other bit of `modeReg` and all of `clkCtlReg`.
- R8: In the first cycle with `sysRstN` = 1 after a reset, `vecFetch` is 1 and `vecAddr` is 24'hFFFFFC. At all other times `vecFetch` is 0 and `vecAddr` is 0.
- R9: While `sysRstN` is 0, register writes and new triggers are ignored. They neither extend the hold nor change `rstCause`.
- R10: If a pending software request and an enabled watchdog underflow are both sampled at the same edge, `rstCause` becomes 2'b10 (software has priority).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = mode register, 1 = clock control register |
| wrData | input | 8 | Write data |
| mainClkSel | input | 1 | 1 when the main clock drives the CPU |
| oscStable | input | 1 | 1 when the main oscillator is stable |
| wdUnderflow | input | 1 | One-cycle underflow event from the watchdog counter |
| sysRstN | output | 1 | System reset to the core, active low |
| rstCause | output | 2 | Last reset source: 01 power-on, 10 software, 11 watchdog |
| wdIrq | output | 1 | One-cycle watchdog interrupt pulse |
| vecFetch | output | 1 | Marks the first cycle after reset release |
| vecAddr | output | 24 | Reset-vector location while `vecFetch` is 1, else 0 |
| modeReg | output | 8 | Mode register readback (bits 1:0 mode, bit 3 software request) |
| clkCtlReg | output | 8 | Clock control register readback (bit 0 watchdog reset enable) |

## Verification
The properties assume that `porN` is low at time zero and that every input changes only away from the active clock edge. They also assume that a software request is never made in the same cycle as another write to the mode register at the edge where the request fires. The stimulus meets these conditions in three ways: it drives all inputs one nanosecond after an edge, it issues each write as its own single-cycle transaction, and it pulses `wdUnderflow` for one cycle only after any earlier write has completed. The mid-run power-on case is the only asynchronous event, and it is applied in the middle of a clock cycle.

// File: rtl/warm_rst_pkg.sv
package warm_rst_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_SW   = 2'b10,
    CAUSE_WDT  = 2'b11
  } rstCause_e;

  // strobes from the control block to the register datapath
  typedef struct packed {
    logic warmClr;   // clear all non-preserved register bits
    logic modeWr;    // load the mode register from write data
    logic clkWr;     // load the clock control register from write data
    logic swAccept;  // software request bit may be stored as written
  } ctlStrobe_t;

  localparam logic SEL_MODE = 1'b0;
  localparam logic SEL_CLK  = 1'b1;

endpackage

// File: rtl/warm_rst_regs.sv
module warm_rst_regs
  import warm_rst_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int PMODE_W = 2,
  parameter int SW_BIT  = 3
) (
  input  logic             clk,
  input  logic             porN,
  input  ctlStrobe_t       strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] modeReg,
  output logic [REG_W-1:0] clkCtlReg
);

  localparam logic [REG_W-1:0] KEEP_MASK = {{(REG_W-PMODE_W){1'b0}}, {PMODE_W{1'b1}}};

  logic [REG_W-1:0] modeNext;

  always_comb begin
    modeNext         = wrData;
    modeNext[SW_BIT] = wrData[SW_BIT] & strobe.swAccept;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      modeReg   <= '0;
      clkCtlReg <= '0;
    end else if (strobe.warmClr) begin
      modeReg   <= modeReg & KEEP_MASK;
      clkCtlReg <= '0;
    end else begin
      if (strobe.modeWr) modeReg   <= modeNext;
      if (strobe.clkWr)  clkCtlReg <= wrData;
    end
  end

endmodule

// File: rtl/warm_rst_ctl.sv
module warm_rst_ctl
  import warm_rst_pkg::*;
#(
  parameter int HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       wrEn,
  input  logic       wrSel,
  input  logic       mainClkSel,
  input  logic       oscStable,
  input  logic       wdUnderflow,
  input  logic       swPending,
  input  logic       wdRstEn,
  output ctlStrobe_t strobe,
  output logic       inReset,
  output rstCause_e  cause,
  output logic       wdIrq,
  output logic       vecFetch
);

  localparam int CNT_W = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic clkOk, swTrig, wdTrig, holdDone;

  always_comb begin
    clkOk           = mainClkSel & oscStable;
    swTrig          = !inReset & swPending;
    wdTrig          = !inReset & wdUnderflow & wdRstEn;
    holdDone        = inReset & (holdCnt == '0);
    strobe.warmClr  = inReset;
    strobe.modeWr   = !inReset & wrEn & (wrSel == SEL_MODE);
    strobe.clkWr    = !inReset & wrEn & (wrSel == SEL_CLK);
    strobe.swAccept = clkOk;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      inReset  <= 1'b1;
      holdCnt  <= CNT_LOAD;
      cause    <= CAUSE_POR;
      wdIrq    <= 1'b0;
      vecFetch <= 1'b0;
    end else begin
      vecFetch <= holdDone;
      wdIrq    <= !inReset & wdUnderflow & !wdRstEn;
      if (inReset) begin
        if (holdDone) inReset <= 1'b0;
        else          holdCnt <= holdCnt - 1'b1;
      end else if (swTrig || wdTrig) begin
        inReset <= 1'b1;
        holdCnt <= CNT_LOAD;
        cause   <= swTrig ? CAUSE_SW : CAUSE_WDT;
      end
    end
  end

endmodule

// File: rtl/warm_rst_ctrl.sv
module warm_rst_ctrl
  import warm_rst_pkg::*;
#(
  parameter int          REG_W       = 8,
  parameter int          PMODE_W     = 2,
  parameter int          SW_BIT      = 3,
  parameter int          WDEN_BIT    = 0,
  parameter int          HOLD_CYCLES = 16,
  parameter int          ADDR_W      = 24,
  parameter logic [23:0] RESET_VEC   = 24'hFFFFFC
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              wrEn,
  input  logic              wrSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic              mainClkSel,
  input  logic              oscStable,
  input  logic              wdUnderflow,
  output logic              sysRstN,
  output logic [1:0]        rstCause,
  output logic              wdIrq,
  output logic              vecFetch,
  output logic [ADDR_W-1:0] vecAddr,
  output logic [REG_W-1:0]  modeReg,
  output logic [REG_W-1:0]  clkCtlReg
);

  ctlStrobe_t strobe;
  rstCause_e  cause;
  logic       inReset;

  warm_rst_ctl #(.HOLD_CYCLES(HOLD_CYCLES)) uCtl (
    .clk        (clk),
    .porN       (porN),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .mainClkSel (mainClkSel),
    .oscStable  (oscStable),
    .wdUnderflow(wdUnderflow),
    .swPending  (modeReg[SW_BIT]),
    .wdRstEn    (clkCtlReg[WDEN_BIT]),
    .strobe     (strobe),
    .inReset    (inReset),
    .cause      (cause),
    .wdIrq      (wdIrq),
    .vecFetch   (vecFetch)
  );

  warm_rst_regs #(.REG_W(REG_W), .PMODE_W(PMODE_W), .SW_BIT(SW_BIT)) uRegs (
    .clk      (clk),
    .porN     (porN),
    .strobe   (strobe),
    .wrData   (wrData),
    .modeReg  (modeReg),
    .clkCtlReg(clkCtlReg)
  );

  assign sysRstN  = !inReset;
  assign rstCause = cause;
  assign vecAddr  = vecFetch ? ADDR_W'(RESET_VEC) : '0;

endmodule

// File: rtl/warm_rst_chk.sv
module warm_rst_chk #(
  parameter int          HOLD_CYCLES = 16,
  parameter int          PMODE_W     = 2,
  parameter int          ADDR_W      = 24,
  parameter logic [23:0] RESET_VEC   = 24'hFFFFFC
) (
  input logic               clk,
  input logic               porN,
  input logic               wrEn,
  input logic               wrSel,
  input logic               wrSwBit,
  input logic               mainClkSel,
  input logic               oscStable,
  input logic               wdUnderflow,
  input logic               sysRstN,
  input logic [1:0]         rstCause,
  input logic               wdIrq,
  input logic               vecFetch,
  input logic [ADDR_W-1:0]  vecAddr,
  input logic [PMODE_W-1:0] pmode,
  input logic               swPend,
  input logic               wdEn,
  input logic [7:0]         clkCtlReg
);

  localparam int LW = $clog2(HOLD_CYCLES + 1) + 1;
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)        lowCnt <= '0;
    else if (!sysRstN) lowCnt <= lowCnt + 1'b1;
    else              lowCnt <= '0;
  end

  AST_HOLD_LEN: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRstN) |-> (lowCnt == LW'(HOLD_CYCLES))); // R2

  AST_SW_FIRE: assert property (@(posedge clk) disable iff (!porN)
    (sysRstN && swPend) |=> (!sysRstN && rstCause == 2'b10)); // R3

  AST_SW_GATE: assert property (@(posedge clk) disable iff (!porN)
    (wrEn && !wrSel && wrSwBit && !(mainClkSel && oscStable)) |=> !swPend); // R4

  AST_WD_FIRE: assert property (@(posedge clk) disable iff (!porN)
    (sysRstN && wdUnderflow && wdEn && !swPend) |=> (!sysRstN && rstCause == 2'b11)); // R5

  AST_WD_IRQ: assert property (@(posedge clk) disable iff (!porN)
    (sysRstN && wdUnderflow && !wdEn && !swPend) |=> (sysRstN && wdIrq)); // R6

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!porN)
    !$past(wrEn) |-> $stable(pmode)); // R7

  AST_WARM_CLR: assert property (@(posedge clk) disable iff (!porN)
    $fell(sysRstN) |=> (clkCtlReg == '0)); // R7

  AST_VEC_OUT: assert property (@(posedge clk) disable iff (!porN)
    $rose(sysRstN) |-> (vecFetch && vecAddr == ADDR_W'(RESET_VEC))); // R8

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!porN)
    !$past(sysRstN) |-> $stable(pmode)); // R9

endmodule

bind warm_rst_ctrl warm_rst_chk #(
  .HOLD_CYCLES(HOLD_CYCLES), .PMODE_W(PMODE_W), .ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)
) uChk (
  .clk        (clk),
  .porN       (porN),
  .wrEn       (wrEn),
  .wrSel      (wrSel),
  .wrSwBit    (wrData[SW_BIT]),
  .mainClkSel (mainClkSel),
  .oscStable  (oscStable),
  .wdUnderflow(wdUnderflow),
  .sysRstN    (sysRstN),
  .rstCause   (rstCause),
  .wdIrq      (wdIrq),
  .vecFetch   (vecFetch),
  .vecAddr    (vecAddr),
  .pmode      (modeReg[PMODE_W-1:0]),
  .swPend     (modeReg[SW_BIT]),
  .wdEn       (clkCtlReg[WDEN_BIT]),
  .clkCtlReg  (clkCtlReg)
);

// File: tb/tb_warm_rst_ctrl.sv
`timescale 1ns/1ps
module tb_warm_rst_ctrl;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic wrEn = 1'b0, wrSel = 1'b0;
  logic [7:0] wrData = '0;
  logic mainClkSel = 1'b1, oscStable = 1'b1, wdUnderflow = 1'b0;
  logic sysRstN, wdIrq, vecFetch;
  logic [1:0] rstCause;
  logic [23:0] vecAddr;
  logic [7:0] modeReg, clkCtlReg;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  warm_rst_ctrl dut (
    .clk(clk), .porN(porN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .mainClkSel(mainClkSel), .oscStable(oscStable), .wdUnderflow(wdUnderflow),
    .sysRstN(sysRstN), .rstCause(rstCause), .wdIrq(wdIrq), .vecFetch(vecFetch),
    .vecAddr(vecAddr), .modeReg(modeReg), .clkCtlReg(clkCtlReg)
  );

  // entry: [8] src 1=watchdog, [7] mainClkSel, [6] oscStable, [5] wd enable,
  //        [4] reset expected, [3:2] expected cause, [1:0] processor mode
  localparam logic [8:0] VECS [7] = '{
    {1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 2'b01},
    {1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 2'b10},
    {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 2'b11},
    {1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b11, 2'b11},
    {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 2'b01},
    {1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 2'b10},
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 2'b11, 2'b00}
  };

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    tick();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic waitRelease(output int n);
    n = 0;
    while (!sysRstN && n < 100) begin
      tick();
      n++;
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    logic [7:0] modeVal, clkVal;

    // cold reset state (R1), hold length (R2), vector (R8)
    tick(); tick(); tick();
    chk("R1 sysRstN", 32'(sysRstN), 0);
    chk("R1 cause", 32'(rstCause), 32'h1);
    chk("R1 regs", {modeReg, clkCtlReg}, 0);
    chk("R8 idle vecFetch", 32'(vecFetch), 0);
    porN = 1'b1;
    waitRelease(n);
    chk("R2 cold hold", n, 16);
    chk("R8 vecFetch", 32'(vecFetch), 1);
    chk("R8 vecAddr", 32'(vecAddr), 32'hFFFFFC);
    tick();
    chk("R8 vecFetch drop", 32'(vecFetch), 0);
    chk("R8 vecAddr drop", 32'(vecAddr), 0);

    // table walk: R3 R4 R5 R6 R7
    for (int i = 0; i < 7; i++) begin
      logic [8:0] e;
      e = VECS[i];
      mainClkSel = e[7]; oscStable = e[6];
      clkVal  = 8'hA4 | {7'b0, e[5]};
      modeVal = 8'hE4 | {6'b0, e[1:0]};
      wr(1'b1, clkVal);
      wr(1'b0, modeVal);
      if (!e[8]) begin
        wr(1'b0, modeVal | 8'h08);
        chk("R4 R3 request bit", 32'(modeReg[3]), 32'(e[4]));
        tick();
        chk("R3 R4 reset", 32'(sysRstN), 32'(!e[4]));
      end else begin
        wdUnderflow = 1'b1;
        tick();
        wdUnderflow = 1'b0;
        chk("R6 irq", 32'(wdIrq), 32'(!e[4]));
        chk("R5 R6 reset", 32'(sysRstN), 32'(!e[4]));
        tick();
        chk("R6 irq one cycle", 32'(wdIrq), 0);
      end
      if (e[4]) begin
        chk("R3 R5 cause", 32'(rstCause), 32'(e[3:2]));
        waitRelease(n);
        chk("R7 mode kept", 32'(modeReg), 32'(e[1:0]));
        chk("R7 clkctl cleared", 32'(clkCtlReg), 0);
        chk("R8 vec after warm", 32'(vecAddr), 32'hFFFFFC);
      end else begin
        chk("R4 regs retained", {modeReg, clkCtlReg}, {modeVal, clkVal});
      end
      mainClkSel = 1'b1; oscStable = 1'b1;
      tick();
    end

    // R2 warm hold length
    wr(1'b1, 8'h01);
    wdUnderflow = 1'b1;
    tick();
    wdUnderflow = 1'b0;
    waitRelease(n);
    chk("R2 warm hold", n, 16);

    // R9 writes and triggers ignored during hold
    wr(1'b0, 8'h02);
    wr(1'b1, 8'h01);
    wdUnderflow = 1'b1;
    tick();
    wdUnderflow = 1'b0;
    wr(1'b0, 8'h0B);
    wdUnderflow = 1'b1;
    tick();
    wdUnderflow = 1'b0;
    waitRelease(n);
    chk("R9 hold not extended", n, 14);
    chk("R9 mode unchanged", 32'(modeReg), 32'h02);
    chk("R9 cause unchanged", 32'(rstCause), 32'h3);

    // R10 simultaneous software and watchdog
    wr(1'b1, 8'h01);
    wr(1'b0, 8'h08);
    wdUnderflow = 1'b1;
    tick();
    wdUnderflow = 1'b0;
    chk("R10 reset", 32'(sysRstN), 0);
    chk("R10 cause", 32'(rstCause), 32'h2);
    waitRelease(n);

    // R1 asynchronous power-on mid-run
    wr(1'b0, 8'h03);
    wr(1'b1, 8'hFE);
    #1 porN = 1'b0;
    #0.5;
    chk("R1 async rst", 32'(sysRstN), 0);
    chk("R1 async regs", {modeReg, clkCtlReg}, 0);
    chk("R1 async cause", 32'(rstCause), 32'h1);
    tick();
    porN = 1'b1;
    waitRelease(n);
    chk("R2 repeat cold hold", n, 16);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule